// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block sits between a register bus and a peripheral's register file and decides which bus writes may reach that file. After reset the gate is closed. It opens only when two key registers hold their exact 32-bit unlock constants, and each key register has its own address. While the gate is closed, writes to protected addresses are dropped without any error indication. While it is open, the same writes are passed downstream through a qualified write strobe.

Any write to a key register is accepted, whatever the lock state. Writing anything other than the key's constant, zero included, closes the gate again. The block also holds a small bank of scratch words. Software can read them at any time, but it can write them only while the gate is open. Reads of downstream addresses are never blocked.

The lock is tracked by a four-state machine:
- `LK_NONE`: neither key holds its constant.
- `LK_FIRST`: only key 0 holds its constant.
- `LK_SECOND`: only key 1 holds its constant.
- `LK_BOTH`: both keys hold their constants, and the gate is open.

The state machine changes state only on key writes:
- A matching key-0 write moves NONE to FIRST and SECOND to BOTH.
- A matching key-1 write moves NONE to SECOND and FIRST to BOTH.
- A non-matching key-0 write moves FIRST to NONE and BOTH to SECOND.
- A non-matching key-1 write moves SECOND to NONE and BOTH to FIRST.
- All other combinations hold the current state.

Top module: `reg_write_lock`

## Requirements
- R1: After reset the gate is closed (`lock_open`=0) and every scratch word reads 0.
- R2: The gate opens on the clock edge that stores the second of two matching key writes. Key 0 at 0x6C must hold 0x83E70B13 and key 1 at 0x70 must hold 0x95A4F1E0, and the two writes may come in either order.
- R3: A matching value in only one key register leaves the gate closed.
- R4: A write of any non-matching value (zero or an off-by-one constant) to either key closes the gate on that write's clock edge.
- R5: While the gate is open, a bus write to any address that is neither a key nor a scratch word drives `periph_wr_en` high in the same cycle.
- R6: While the gate is closed, a write to a protected address leaves `periph_wr_en` low.
- R7: While the gate is open, a write to a scratch word at 0x60, 0x64 or 0x68 is stored and reads back on `bus_rdata`.
- R8: While the gate is closed, a write to a scratch word has no effect: the word still reads its earlier value.
- R9: Key addresses read back as 0, so the unlock constants cannot be read.
- R10: A read of any address other than a key or a scratch word returns `periph_rdata` unchanged, whether the gate is open or closed. Scratch words stay readable while the gate is closed.
- R11: A write to a key register never raises `periph_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on `bus_addr` |
| periph_rdata | input | DATA_W | Read data from the protected register file |
| periph_wr_en | output | 1 | Qualified write strobe for the protected register file |
| lock_open | output | 1 | High while both keys hold their constants |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 32-bit data, three scratch words starting at 0x60, and keys at 0x6C and 0x70. With these values the address just below the scratch window (0x5C) and the addresses that border the key registers can be reached, so mistakes in the window decode can be seen. The stimulus table runs through all four lock states and both unlock orders. It also applies an off-by-one key value and a re-lock from the fully open state. A reset issued while the gate is open confirms that both the lock and the scratch contents return to their reset state.

// File: rtl/reg_write_lock_pkg.sv
package reg_write_lock_pkg;

    typedef enum logic [1:0] {
        LK_NONE   = 2'b00,
        LK_FIRST  = 2'b01,
        LK_SECOND = 2'b10,
        LK_BOTH   = 2'b11
    } lock_state_t;

    localparam logic [31:0] DEF_KEY0_VAL = 32'h83E7_0B13;
    localparam logic [31:0] DEF_KEY1_VAL = 32'h95A4_F1E0;

endpackage

// File: rtl/key_lock_fsm.sv
module key_lock_fsm
    import reg_write_lock_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] KEY0_VAL = DEF_KEY0_VAL,
    parameter logic [31:0] KEY1_VAL = DEF_KEY1_VAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_key0,
    input  logic              wr_key1,
    input  logic [DATA_W-1:0] wdata,
    output logic              open
);

    lock_state_t state_q, state_d;
    logic hit0, hit1, miss0, miss1;

    assign hit0  = wr_key0 && (wdata == DATA_W'(KEY0_VAL));
    assign hit1  = wr_key1 && (wdata == DATA_W'(KEY1_VAL));
    assign miss0 = wr_key0 && !hit0;
    assign miss1 = wr_key1 && !hit1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_NONE: begin
                if (hit0)      state_d = LK_FIRST;
                else if (hit1) state_d = LK_SECOND;
            end
            LK_FIRST: begin
                if (miss0)     state_d = LK_NONE;
                else if (hit1) state_d = LK_BOTH;
            end
            LK_SECOND: begin
                if (miss1)     state_d = LK_NONE;
                else if (hit0) state_d = LK_BOTH;
            end
            LK_BOTH: begin
                if (miss0)      state_d = LK_SECOND;
                else if (miss1) state_d = LK_FIRST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        open = (state_q == LK_BOTH);
    end

    AST_MISS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (miss0 || miss1) |=> !open); // R4
    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(wr_key0 || wr_key1)); // R2
    AST_ONE_KEY_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !(wr_key0 || wr_key1)) |=> !open); // R3

endmodule

// File: rtl/scratch_bank.sv
module scratch_bank #(
    parameter int DATA_W = 32,
    parameter int NUM_W  = 3,
    localparam int IDX_W = (NUM_W > 1) ? $clog2(NUM_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] word_q [NUM_W];

    for (genvar g = 0; g < NUM_W; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                word_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_W; i++) begin
            if (rd_idx == IDX_W'(i)) rdata = word_q[i];
        end
    end

endmodule

// File: rtl/reg_write_lock.sv
module reg_write_lock
    import reg_write_lock_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          NUM_SCR   = 3,
    parameter logic [31:0] SCR_BASE  = 32'h60,
    parameter logic [31:0] KEY0_ADDR = 32'h6C,
    parameter logic [31:0] KEY1_ADDR = 32'h70,
    parameter logic [31:0] KEY0_VAL  = DEF_KEY0_VAL,
    parameter logic [31:0] KEY1_VAL  = DEF_KEY1_VAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic              periph_wr_en,
    output logic              lock_open
);

    localparam int          IDX_W   = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1;
    localparam logic [31:0] SCR_END = SCR_BASE + 32'(4 * NUM_SCR);

    logic              is_key0, is_key1, is_scr;
    logic [31:0]       addr_ext, scr_off;
    logic [IDX_W-1:0]  scr_idx;
    logic [DATA_W-1:0] scr_rdata;
    logic              gate_open;

    assign addr_ext = 32'(bus_addr);
    assign scr_off  = addr_ext - SCR_BASE;
    assign is_key0  = (addr_ext == KEY0_ADDR);
    assign is_key1  = (addr_ext == KEY1_ADDR);
    assign is_scr   = (addr_ext >= SCR_BASE) && (addr_ext < SCR_END)
                      && (scr_off[1:0] == 2'b00);
    assign scr_idx  = scr_off[IDX_W+1:2];

    key_lock_fsm #(
        .DATA_W  (DATA_W),
        .KEY0_VAL(KEY0_VAL),
        .KEY1_VAL(KEY1_VAL)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_key0(bus_wr_en && is_key0),
        .wr_key1(bus_wr_en && is_key1),
        .wdata  (bus_wdata),
        .open   (gate_open)
    );

    scratch_bank #(
        .DATA_W(DATA_W),
        .NUM_W (NUM_SCR)
    ) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr_en && is_scr && gate_open),
        .wr_idx(scr_idx),
        .wdata (bus_wdata),
        .rd_idx(scr_idx),
        .rdata (scr_rdata)
    );

    always_comb begin
        periph_wr_en = bus_wr_en && gate_open && !is_key0 && !is_key1 && !is_scr;
        lock_open    = gate_open;
        if (is_key0 || is_key1) bus_rdata = '0;
        else if (is_scr)        bus_rdata = scr_rdata;
        else                    bus_rdata = periph_rdata;
    end

    AST_STROBE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        periph_wr_en |-> lock_open); // R6
    AST_NO_KEY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && (is_key0 || is_key1)) |-> !periph_wr_en); // R11
    AST_SCR_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && is_scr && !lock_open) |=> $stable(scr_rdata)); // R8
    AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_key0 || is_key1) |-> (bus_rdata == '0)); // R9

endmodule

// File: tb/reg_write_lock_bench.sv
`timescale 1ns/1ps
module reg_write_lock_bench;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        pwe;
        logic        open;
        logic [31:0] rd;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;
    localparam int NV = 25;

    // wr, addr, data, exp periph_wr_en, exp open after edge, exp rdata (reads), requirement
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h60, 32'h0,        1'b0, 1'b0, 32'h0,        4'd1},  // R1
        '{1'b1, 8'h10, 32'h1,        1'b0, 1'b0, 32'h0,        4'd6},  // R6
        '{1'b1, 8'h60, 32'hAA,       1'b0, 1'b0, 32'h0,        4'd8},  // R8
        '{1'b0, 8'h60, 32'h0,        1'b0, 1'b0, 32'h0,        4'd8},  // R8
        '{1'b1, 8'h6C, K0,           1'b0, 1'b0, 32'h0,        4'd3},  // R3
        '{1'b1, 8'h70, K1,           1'b0, 1'b1, 32'h0,        4'd2},  // R2
        '{1'b1, 8'h10, 32'h5,        1'b1, 1'b1, 32'h0,        4'd5},  // R5
        '{1'b1, 8'h5C, 32'h6,        1'b1, 1'b1, 32'h0,        4'd5},  // R5
        '{1'b1, 8'h64, 32'h1234,     1'b0, 1'b1, 32'h0,        4'd7},  // R7
        '{1'b0, 8'h64, 32'h0,        1'b0, 1'b1, 32'h1234,     4'd7},  // R7
        '{1'b0, 8'h6C, 32'h0,        1'b0, 1'b1, 32'h0,        4'd9},  // R9
        '{1'b0, 8'h70, 32'h0,        1'b0, 1'b1, 32'h0,        4'd9},  // R9
        '{1'b0, 8'h10, 32'h0,        1'b0, 1'b1, 32'h5000_0010, 4'd10}, // R10
        '{1'b1, 8'h70, 32'h0,        1'b0, 1'b0, 32'h0,        4'd4},  // R4
        '{1'b0, 8'h64, 32'h0,        1'b0, 1'b0, 32'h1234,     4'd10}, // R10
        '{1'b1, 8'h64, 32'h9999,     1'b0, 1'b0, 32'h0,        4'd8},  // R8
        '{1'b0, 8'h64, 32'h0,        1'b0, 1'b0, 32'h1234,     4'd8},  // R8
        '{1'b0, 8'h5C, 32'h0,        1'b0, 1'b0, 32'h5000_005C, 4'd10}, // R10
        '{1'b1, 8'h70, K1,           1'b0, 1'b1, 32'h0,        4'd2},  // R2
        '{1'b1, 8'h6C, 32'h83E70B12, 1'b0, 1'b0, 32'h0,        4'd4},  // R4
        '{1'b1, 8'h6C, K0,           1'b0, 1'b1, 32'h0,        4'd2},  // R2
        '{1'b1, 8'h6C, K0,           1'b0, 1'b1, 32'h0,        4'd11}, // R11
        '{1'b1, 8'h6C, 32'h0,        1'b0, 1'b0, 32'h0,        4'd4},  // R4
        '{1'b1, 8'h70, 32'h0,        1'b0, 1'b0, 32'h0,        4'd4},  // R4
        '{1'b0, 8'h68, 32'h0,        1'b0, 1'b0, 32'h0,        4'd1}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] periph_rdata;
    logic        periph_wr_en;
    logic        lock_open;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;
    assign periph_rdata = 32'h5000_0000 | {24'h0, bus_addr};

    reg_write_lock u_reg_write_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_en   (bus_wr_en),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .periph_rdata(periph_rdata),
        .periph_wr_en(periph_wr_en),
        .lock_open   (lock_open)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_step(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = wr;
        bus_addr  = a;
        bus_wdata = d;
        #1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 open at reset", 32'(lock_open), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d row %0d", VEC[i].req, i);
            bus_step(VEC[i].wr, VEC[i].addr, VEC[i].data);
            check({tag, " wr_en"}, 32'(periph_wr_en), 32'(VEC[i].pwe));
            if (!VEC[i].wr) check({tag, " rdata"}, bus_rdata, VEC[i].rd);
            @(posedge clk);
            #1;
            check({tag, " open"}, 32'(lock_open), 32'(VEC[i].open));
        end

        // R2 reverse order unlock, then R7 store, then reset while open (R1)
        bus_step(1'b1, 8'h70, K1);
        bus_step(1'b1, 8'h6C, K0);
        bus_step(1'b1, 8'h68, 32'hBEEF);
        check("R2 open key1-first", 32'(lock_open), 32'h1);
        bus_step(1'b0, 8'h68, 32'h0);
        check("R7 scratch2 readback", bus_rdata, 32'hBEEF);
        rst_n = 1'b0;
        #1;
        check("R1 open after reset", 32'(lock_open), 32'h0);
        check("R1 scratch after reset", bus_rdata, 32'h0);
        bus_step(1'b1, 8'h20, 32'h7);
        check("R6 write after reset", 32'(periph_wr_en), 32'h0);
        rst_n = 1'b1;
        bus_step(1'b1, 8'h20, 32'h7);
        check("R6 locked after reset", 32'(periph_wr_en), 32'h0);
        bus_step(1'b0, 8'h00, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule